// File: doc/BRIEF.md
# Serial Command Receiver with Display-Memory Writer

This block sits at the control edge of an on-screen display engine. A host sends 16-bit command words over a three-wire link: an active-low select, a shift clock and a data line. A static strap picks the bit order of each frame. The block brings the three link wires into the core clock domain and rebuilds each word. It then decodes the 4-bit command field in the top nibble of the word.

Five commands drive the display memories. One command loads a row/column write pointer and a fill flag. Two commands together build a 24-bit character entry, and two more build a 24-bit line entry. Each entry is made of two 12-bit halves: the first command of a pair is only held, and the second command combines both halves and commits the entry. A character commit moves the pointer forward in raster order. A line commit leaves the pointer where it is. When the fill flag is set, one character commit copies the entry into every character cell from the pointer to the end of the array, one cell per clock. All writes wait while horizontal sync is active and go out once it ends. Every other command code is passed on a one-cycle strobe port to the control registers of the display engine.

Top module: `osd_cmd_rx`

## Requirements
- R1: A frame is the bits shifted on rising shift-clock edges while select is low, ending when select rises. With `msb_first` high the first bit received is bit 15; with it low the first bit is bit 0.
- R2: A frame that did not have exactly 16 shift-clock rising edges while select was low has no effect on any output.
- R3: Bits 15:12 hold the command code. Codes 5 to 15 produce a one-cycle `ctl_we` pulse with `ctl_op` equal to the code and `ctl_data` equal to bits 11:0. Codes 0 to 4 never pulse `ctl_we`.
- R4: Code 0 loads the row from bits 11:8 (0 to 11), the fill flag from bit 7 and the column from bits 4:0 (0 to 27). Bits 6:5 are ignored.
- R5: Code 1 stores bits 11:0 as the upper half of the next character entry and writes nothing.
- R6: Code 2 writes the 24-bit entry {held code-1 bits, own bits 11:0} at the current row and column. The pointer then advances by one cell.
- R7: Advancing from column 27 goes to column 0 of the next row. Advancing from row 11, column 27 goes to row 0, column 0.
- R8: Code 3 stores an upper half. Code 4 writes {held code-3 bits, own bits 11:0} to the line memory at the current row, and the pointer is not changed.
- R9: While `hsync_act` is high, `chr_we` and `line_we` stay low. A write requested during sync is issued once sync goes low.
- R10: With the fill flag set, code 2 writes its entry to every cell from the current cell through row 11, column 27. It writes one cell per clock, pauses during sync, and holds `fill_busy` high throughout. The pointer ends at row 0, column 0.
- R11: After reset all strobes are low, `fill_busy` is low, the fill flag is clear and the pointer is at row 0, column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_cs_n | input | 1 | Link select, low during a frame |
| ser_clk | input | 1 | Link shift clock, data taken on rising edge |
| ser_dat | input | 1 | Link serial data |
| msb_first | input | 1 | Bit order strap: 1 = bit 15 first, 0 = bit 0 first |
| hsync_act | input | 1 | Horizontal sync active, inhibits memory writes |
| chr_we | output | 1 | Character memory write strobe |
| chr_row | output | 4 | Character write row (also the line write row source) |
| chr_col | output | 5 | Character write column |
| chr_data | output | 24 | Character entry |
| line_we | output | 1 | Line memory write strobe |
| line_row | output | 4 | Line write row |
| line_data | output | 24 | Line entry |
| fill_busy | output | 1 | Fill sweep in progress |
| ctl_we | output | 1 | Control register write strobe |
| ctl_op | output | 4 | Command code for the control write |
| ctl_data | output | 12 | Payload for the control write |

## Verification
Select, shift clock and data each pass two synchronizer flops and one edge-detect flop. A frame is therefore decoded four core cycles after select rises, and a commit's write strobe is high during the fifth cycle. The bench drives inputs just after a rising edge and logs every strobe at the falling edge. After each frame it waits ten cycles before it compares the logged writes, so every result has settled. A fill sweep is allowed up to one cell per clock plus the sync pause before its count and contents are checked.

// File: rtl/osd_cmd_pkg.sv
package osd_cmd_pkg;
   localparam int OP_W = 4;
   localparam logic [OP_W-1:0] OP_ADDR   = 4'h0;
   localparam logic [OP_W-1:0] OP_CHR_HI = 4'h1;
   localparam logic [OP_W-1:0] OP_CHR_LO = 4'h2;
   localparam logic [OP_W-1:0] OP_LIN_HI = 4'h3;
   localparam logic [OP_W-1:0] OP_LIN_LO = 4'h4;
   localparam int FILL_BIT  = 7;
   localparam int ROW_LSB   = 8;
endpackage

// File: rtl/osd_ser_shift.sv
module osd_ser_shift #(
   parameter int WORD        = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cs_n,
   input  logic            sclk,
   input  logic            sdat,
   input  logic            msb_first,
   output logic            frame_vld,
   output logic [WORD-1:0] frame_word
);
   localparam int CNT_W = $clog2(WORD + 2);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD);
   localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD + 1);

   logic cs_s, ck_s, dt_s;

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (SYNC_STAGES == 1) begin : g_sync1
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) begin
               cs_s <= 1'b1; ck_s <= 1'b0; dt_s <= 1'b0;
            end else begin
               cs_s <= cs_n; ck_s <= sclk; dt_s <= sdat;
            end
      end else begin : g_syncn
         logic [SYNC_STAGES-1:0] cs_q, ck_q, dt_q;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) begin
               cs_q <= '1; ck_q <= '0; dt_q <= '0;
            end else begin
               cs_q <= {cs_q[SYNC_STAGES-2:0], cs_n};
               ck_q <= {ck_q[SYNC_STAGES-2:0], sclk};
               dt_q <= {dt_q[SYNC_STAGES-2:0], sdat};
            end
         assign cs_s = cs_q[SYNC_STAGES-1];
         assign ck_s = ck_q[SYNC_STAGES-1];
         assign dt_s = dt_q[SYNC_STAGES-1];
      end
   endgenerate

   logic            cs_prev, ck_prev;
   logic [CNT_W-1:0] cnt;
   logic [WORD-1:0] sh;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         cs_prev    <= 1'b1;
         ck_prev    <= 1'b0;
         cnt        <= '0;
         sh         <= '0;
         frame_vld  <= 1'b0;
         frame_word <= '0;
      end else begin
         cs_prev   <= cs_s;
         ck_prev   <= ck_s;
         frame_vld <= 1'b0;
         if (cs_s && !cs_prev) begin
            frame_vld  <= (cnt == CNT_FULL);
            frame_word <= sh;
            cnt        <= '0;
         end else if (!cs_s && cs_prev) begin
            cnt <= '0;
         end else if (!cs_s && ck_s && !ck_prev) begin
            sh <= msb_first ? {sh[WORD-2:0], dt_s} : {dt_s, sh[WORD-1:1]};
            if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
         end
      end
endmodule

// File: rtl/osd_wr_addr.sv
module osd_wr_addr #(
   parameter int ROWS = 12,
   parameter int COLS = 28
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic [$clog2(ROWS)-1:0] ld_row,
   input  logic [$clog2(COLS)-1:0] ld_col,
   input  logic                    step,
   output logic [$clog2(ROWS)-1:0] row,
   output logic [$clog2(COLS)-1:0] col,
   output logic                    at_end
);
   localparam int RW = $clog2(ROWS);
   localparam int CW = $clog2(COLS);
   localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);
   localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);

   assign at_end = (row == ROW_LAST) && (col == COL_LAST);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         row <= '0;
         col <= '0;
      end else if (load) begin
         row <= ld_row;
         col <= ld_col;
      end else if (step) begin
         if (col == COL_LAST) begin
            col <= '0;
            row <= (row == ROW_LAST) ? '0 : row + 1'b1;
         end else begin
            col <= col + 1'b1;
         end
      end
endmodule

// File: rtl/osd_cmd_rx.sv
module osd_cmd_rx
   import osd_cmd_pkg::*;
#(
   parameter int ROWS        = 12,
   parameter int COLS        = 28,
   parameter int WORD        = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ser_cs_n,
   input  logic                      ser_clk,
   input  logic                      ser_dat,
   input  logic                      msb_first,
   input  logic                      hsync_act,
   output logic                      chr_we,
   output logic [$clog2(ROWS)-1:0]   chr_row,
   output logic [$clog2(COLS)-1:0]   chr_col,
   output logic [2*(WORD-4)-1:0]     chr_data,
   output logic                      line_we,
   output logic [$clog2(ROWS)-1:0]   line_row,
   output logic [2*(WORD-4)-1:0]     line_data,
   output logic                      fill_busy,
   output logic                      ctl_we,
   output logic [3:0]                ctl_op,
   output logic [WORD-5:0]           ctl_data
);
   localparam int PAY = WORD - OP_W;
   localparam int DW  = 2 * PAY;
   localparam int RW  = $clog2(ROWS);
   localparam int CW  = $clog2(COLS);

   generate
      if (WORD != 16) begin : g_bad_word
         $error("command word layout needs WORD == 16");
      end
      if (RW > 4 || CW > 5 || ROWS < 2 || COLS < 2) begin : g_bad_geom
         $error("array geometry does not fit the address fields");
      end
   endgenerate

   logic            frm_vld;
   logic [WORD-1:0] frm;
   logic [OP_W-1:0] op;
   logic [PAY-1:0]  pay;
   logic            at_end, addr_load;
   logic [PAY-1:0]  chr_hold, lin_hold;
   logic            fill_en, chr_pend, lin_pend;

   osd_ser_shift #(.WORD(WORD), .SYNC_STAGES(SYNC_STAGES)) u_shift (
      .clk(clk), .rst_n(rst_n), .cs_n(ser_cs_n), .sclk(ser_clk), .sdat(ser_dat),
      .msb_first(msb_first), .frame_vld(frm_vld), .frame_word(frm)
   );

   assign op        = frm[WORD-1 -: OP_W];
   assign pay       = frm[PAY-1:0];
   assign addr_load = frm_vld && (op == OP_ADDR);

   assign chr_we  = (chr_pend | fill_busy) & ~hsync_act;
   assign line_we = lin_pend & ~hsync_act;

   osd_wr_addr #(.ROWS(ROWS), .COLS(COLS)) u_addr (
      .clk(clk), .rst_n(rst_n), .load(addr_load),
      .ld_row(frm[ROW_LSB +: RW]), .ld_col(frm[0 +: CW]),
      .step(chr_we), .row(chr_row), .col(chr_col), .at_end(at_end)
   );

   assign line_row = chr_row;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         chr_hold  <= '0;
         lin_hold  <= '0;
         fill_en   <= 1'b0;
         chr_pend  <= 1'b0;
         lin_pend  <= 1'b0;
         fill_busy <= 1'b0;
         chr_data  <= '0;
         line_data <= '0;
         ctl_we    <= 1'b0;
         ctl_op    <= '0;
         ctl_data  <= '0;
      end else begin
         ctl_we <= 1'b0;
         if (chr_we && !fill_busy)         chr_pend  <= 1'b0;
         if (chr_we && fill_busy && at_end) fill_busy <= 1'b0;
         if (line_we)                       lin_pend  <= 1'b0;
         if (frm_vld) begin
            case (op)
               OP_ADDR:   fill_en  <= frm[FILL_BIT];
               OP_CHR_HI: chr_hold <= pay;
               OP_CHR_LO: begin
                  chr_data <= {chr_hold, pay};
                  if (fill_en) fill_busy <= 1'b1;
                  else         chr_pend  <= 1'b1;
               end
               OP_LIN_HI: lin_hold <= pay;
               OP_LIN_LO: begin
                  line_data <= {lin_hold, pay};
                  lin_pend  <= 1'b1;
               end
               default: begin
                  ctl_we   <= 1'b1;
                  ctl_op   <= op;
                  ctl_data <= pay;
               end
            endcase
         end
      end
endmodule

// File: rtl/osd_cmd_rx_chk.sv
module osd_cmd_rx_chk #(
   parameter int ROWS = 12,
   parameter int COLS = 28
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    hsync_act,
   input logic                    chr_we,
   input logic [$clog2(ROWS)-1:0] chr_row,
   input logic [$clog2(COLS)-1:0] chr_col,
   input logic                    line_we,
   input logic                    fill_busy,
   input logic                    ctl_we,
   input logic [3:0]              ctl_op
);
   a_r9_no_write_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
      hsync_act |-> (!chr_we && !line_we));

   a_r7_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      chr_we |-> (32'(chr_row) < ROWS && 32'(chr_col) < COLS));

   a_r10_fill_step: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_busy && chr_we && $past(fill_busy && chr_we)) |->
         ((chr_row == $past(chr_row) && 32'(chr_col) == 32'($past(chr_col)) + 1) ||
          (chr_col == '0 && 32'(chr_row) == 32'($past(chr_row)) + 1)));

   a_r10_fill_ends_home: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fill_busy) |-> (chr_row == '0 && chr_col == '0));

   a_r3_ctl_codes: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we |-> (ctl_op > 4'd4));

   a_r8_line_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (line_we && !chr_we) |=> (chr_row == $past(chr_row) && chr_col == $past(chr_col)));
endmodule

bind osd_cmd_rx osd_cmd_rx_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
   .clk(clk), .rst_n(rst_n), .hsync_act(hsync_act), .chr_we(chr_we),
   .chr_row(chr_row), .chr_col(chr_col), .line_we(line_we),
   .fill_busy(fill_busy), .ctl_we(ctl_we), .ctl_op(ctl_op)
);

// File: tb/tb_osd_cmd_rx.sv
module tb_osd_cmd_rx;
   localparam int NCELL = 336;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ser_cs_n = 1'b1, ser_clk = 1'b0, ser_dat = 1'b0, msb_first = 1'b0, hsync_act = 1'b0;
   logic chr_we, line_we, fill_busy, ctl_we;
   logic [3:0] chr_row, line_row, ctl_op;
   logic [4:0] chr_col;
   logic [23:0] chr_data, line_data;
   logic [11:0] ctl_data;

   always #4 clk = ~clk;

   osd_cmd_rx dut (
      .clk(clk), .rst_n(rst_n), .ser_cs_n(ser_cs_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
      .msb_first(msb_first), .hsync_act(hsync_act), .chr_we(chr_we), .chr_row(chr_row),
      .chr_col(chr_col), .chr_data(chr_data), .line_we(line_we), .line_row(line_row),
      .line_data(line_data), .fill_busy(fill_busy), .ctl_we(ctl_we), .ctl_op(ctl_op),
      .ctl_data(ctl_data)
   );

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   logic [23:0] mem [NCELL];
   int wr_cnt = 0, ln_cnt = 0, ctl_cnt = 0, last_idx = -1;
   logic [3:0]  last_ln_row;
   logic [23:0] last_ln_data;
   logic [3:0]  last_op;
   logic [11:0] last_cdata;
   bit busy_seen = 1'b0;

   always @(negedge clk) if (rst_n) begin
      if (chr_we) begin
         last_idx = int'(chr_row) * 28 + int'(chr_col);
         if (last_idx < NCELL) mem[last_idx] = chr_data;
         wr_cnt++;
         if (fill_busy) busy_seen = 1'b1;
      end
      if (line_we) begin ln_cnt++; last_ln_row = line_row; last_ln_data = line_data; end
      if (ctl_we)  begin ctl_cnt++; last_op = ctl_op; last_cdata = ctl_data; end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic send_n(input logic [31:0] w, input int n, input bit msb, input int tail);
      tick(1);
      msb_first = msb;
      ser_cs_n  = 1'b0;
      for (int i = 0; i < n; i++) begin
         ser_dat = msb ? w[n-1-i] : w[i];
         tick(3); ser_clk = 1'b1;
         tick(3); ser_clk = 1'b0;
      end
      tick(3);
      ser_cs_n = 1'b1;
      if (tail > 0) tick(tail);
   endtask

   task automatic send(input logic [15:0] w, input bit msb);
      send_n({16'h0, w}, 16, msb, 10);
   endtask

   function automatic logic [15:0] w_addr(input int r, input int c, input bit f);
      return {4'h0, 4'(r), f, 2'b00, 5'(c)};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      int w0, c0, l0, e;
      logic [23:0] keep, v;
      tick(3);
      // R11: reset state
      chk(!chr_we && !line_we && !ctl_we, "R11 strobes low", {chr_we, line_we, ctl_we}, 0);
      chk(!fill_busy, "R11 busy low", fill_busy, 0);
      rst_n = 1'b1;
      tick(3);

      // R5 / R6 / R11: attribute held, commit lands at 0,0 after reset
      send(16'h1ABC, 1'b0);
      chk(wr_cnt == 0, "R5 no write on upper half", wr_cnt, 0);
      send(16'h2123, 1'b0);
      chk(wr_cnt == 1, "R6 one write", wr_cnt, 1);
      chk(last_idx == 0, "R11 pointer at home", last_idx, 0);
      chk(mem[0] == 24'hABC123, "R6 entry merge", mem[0], 24'hABC123);

      // R1 / R3: control codes in both bit orders
      for (int op = 5; op < 16; op++) begin
         for (int m = 0; m < 2; m++) begin
            logic [11:0] p;
            p = 12'(op * 273 + m * 2048 + 5);
            c0 = ctl_cnt;
            send({4'(op), p}, m[0]);
            chk(ctl_cnt == c0 + 1, "R1 frame accepted", ctl_cnt, c0 + 1);
            chk(last_op == 4'(op) && last_cdata == p, "R3 ctl fields",
                {last_op, last_cdata}, {4'(op), p});
         end
      end

      // R2: wrong bit counts are dropped
      c0 = ctl_cnt; w0 = wr_cnt;
      send_n(32'h7555, 15, 1'b1, 10);
      chk(ctl_cnt == c0, "R2 short frame dropped", ctl_cnt, c0);
      send_n(32'h0E555, 17, 1'b0, 10);
      send_n(32'h1E555, 17, 1'b1, 10);
      chk(ctl_cnt == c0 && wr_cnt == w0, "R2 long frame dropped", ctl_cnt, c0);

      // R4 / R6 / R7: sweep across the row end and the array end
      send(w_addr(11, 20, 1'b0) | 16'h0060, 1'b1);
      for (int k = 0; k < 12; k++) begin
         logic [11:0] hi, lo;
         hi = 12'h100 + 12'(k); lo = 12'h200 + 12'(k * 3);
         e = (11 * 28 + 20 + k) % NCELL;
         w0 = wr_cnt;
         send({4'h1, hi}, k[0]);
         send({4'h2, lo}, k[1]);
         chk(wr_cnt == w0 + 1 && last_idx == e, "R7 pointer sequence", last_idx, e);
         chk(mem[e] == {hi, lo}, "R4 write data at loaded cell", mem[e], {hi, lo});
      end

      // R8: line entry, pointer untouched
      send(w_addr(5, 3, 1'b0), 1'b0);
      l0 = ln_cnt; w0 = wr_cnt;
      send(16'h35A5, 1'b0);
      chk(ln_cnt == l0, "R8 no line write on upper half", ln_cnt, l0);
      send(16'h43C3, 1'b1);
      chk(ln_cnt == l0 + 1 && last_ln_row == 4'd5, "R8 line row", last_ln_row, 5);
      chk(last_ln_data == 24'h5A53C3, "R8 line data", last_ln_data, 24'h5A53C3);
      send(16'h1011, 1'b0);
      send(16'h2022, 1'b0);
      chk(last_idx == 5 * 28 + 3 && wr_cnt == w0 + 1, "R8 pointer unchanged", last_idx, 143);

      // R9: writes held during sync
      hsync_act = 1'b1;
      w0 = wr_cnt; l0 = ln_cnt;
      send(16'h1333, 1'b1);
      send(16'h2444, 1'b1);
      send(16'h3555, 1'b0);
      send(16'h4666, 1'b0);
      tick(20);
      chk(wr_cnt == w0 && ln_cnt == l0, "R9 inhibited in sync", wr_cnt, w0);
      hsync_act = 1'b0;
      tick(4);
      chk(wr_cnt == w0 + 1 && mem[144] == 24'h333444, "R9 char released", mem[144], 24'h333444);
      chk(ln_cnt == l0 + 1 && last_ln_data == 24'h555666, "R9 line released", last_ln_data, 24'h555666);

      // R10: partial fill with a sync pause
      keep = mem[284];
      send(w_addr(10, 5, 1'b1), 1'b1);
      send(16'h10F0, 1'b1);
      w0 = wr_cnt; busy_seen = 1'b0;
      send_n({16'h0, 16'h2A5A}, 16, 1'b1, 0);
      tick(8);  hsync_act = 1'b1;
      tick(10); hsync_act = 1'b0;
      tick(80);
      chk(wr_cnt == w0 + 51, "R10 fill count", wr_cnt - w0, 51);
      e = 0;
      for (int i = 285; i < NCELL; i++) if (mem[i] !== 24'h0F0A5A) e++;
      chk(e == 0, "R10 fill contents", e, 0);
      chk(mem[284] === keep, "R10 cell before start untouched", mem[284], keep);
      chk(busy_seen && !fill_busy, "R10 busy during, low after", {busy_seen, fill_busy}, 2'b10);
      chk(last_idx == NCELL - 1, "R10 last cell", last_idx, NCELL - 1);

      // R10 / R7: pointer came home, so the next fill covers the whole array
      send(16'h1777, 1'b0);
      w0 = wr_cnt;
      send_n({16'h0, 16'h2888}, 16, 1'b0, 400);
      chk(wr_cnt == w0 + NCELL, "R10 full fill from home", wr_cnt - w0, NCELL);
      e = 0;
      for (int i = 0; i < NCELL; i++) begin v = mem[i]; if (v !== 24'h777888) e++; end
      chk(e == 0, "R7 wrap to home cell", e, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule